// File: doc/BRIEF.md
# Pin Event Flag Unit

This unit watches a group of already-filtered digital pin levels and turns selected level or edge conditions into sticky per-pin event flags. Each pin has its own 4-bit mode code. The code chooses the condition to watch: low level, high level, rising edge, falling edge or both edges. It also chooses whether a flag on that pin feeds the processor interrupt line or the DMA request line. Edges are found by comparing a pin's present level with the level it had one clock earlier.

Software reaches the unit through a simple single-cycle register port. Writes have no handshake and no back-pressure; a write takes effect at the clock edge on which `reg_wr` is high, and reads return data combinationally from `reg_addr`. There is one control word per pin, holding the mode code and that pin's flag, and one port-wide status word that holds every flag. A flag is cleared by writing a one to it. A flag on a pin in a DMA mode is also cleared when the DMA engine strobes that pin's completion input. A level condition that is still true sets its flag again on the same edge that would clear it.

Top module: `pin_evt_detect`

## Requirements
- R1: Mode code 0x0 and every code outside {0x1, 0x2, 0x3, 0x8, 0x9, 0xA, 0xB, 0xC} never set the pin's flag.
- R2: Codes 0x1, 0x2 and 0x3 set the flag on a rising edge, a falling edge and either edge respectively, and a flag on such a pin drives the DMA request.
- R3: Codes 0x9, 0xA and 0xB set the flag on a rising edge, a falling edge and either edge respectively, and a flag on such a pin drives the interrupt.
- R4: Code 0x8 sets the flag in every cycle the pin is low and code 0xC in every cycle it is high, so a clear issued while the condition holds leaves the flag set.
- R5: Writing pin p's control word (address p) with bit 8 set clears that pin's flag; with bit 8 clear the flag is left as it is. The same write loads bits [3:0] as the pin's new mode code.
- R6: Writing the status word (address NPINS) clears each flag whose data bit is one and leaves the others; reading it returns the flag vector in bits [NPINS-1:0].
- R7: A pulse on `dma_done[p]` clears pin p's flag only while the pin's mode is 0x1, 0x2 or 0x3; in any other mode it has no effect.
- R8: When a set condition and any clear (write or DMA completion) hit the same pin in the same cycle, the flag ends up set.
- R9: `irq` is the OR of flags on pins whose mode is 0x8 to 0xC; `dma_req` is the OR of flags on pins whose mode is 0x1 to 0x3.
- R10: Reading a control word returns the mode code in bits [3:0], the flag in bit 8 and zeros elsewhere; addresses above NPINS read as zero and writes to them change nothing.
- R11: After reset all flags are clear, all modes are 0x0, and `irq` and `dma_req` are low.
- R12: A flag sets at the clock edge that ends the first cycle in which the new level is present, and is visible on `flags` just after that edge; a level held steady produces no further edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | NPINS | Filtered pin levels |
| dma_done | input | NPINS | Per-pin DMA completion strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | AW | Register address: 0..NPINS-1 control words, NPINS status word |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 1 | Combined DMA request |
| flags | output | NPINS | Per-pin event flags |

## Verification
The bench builds the unit with NPINS set to 8, which gives a 16-bit data word and a 4-bit address. Every pin can then be given its own scenario, the status word sits at address 8 and the unused addresses 9 to 15 can be driven to prove they do nothing. A table walks all defined codes and two undefined ones on pin 0 through chosen level transitions. Directed sequences then cover level re-set, clear priority, DMA completion in both mode classes and partial status clears.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  localparam int unsigned MODE_W   = 4;
  localparam int unsigned FLAG_BIT = 8;

  localparam logic [MODE_W-1:0] M_OFF      = 4'h0;
  localparam logic [MODE_W-1:0] M_DMA_RISE = 4'h1;
  localparam logic [MODE_W-1:0] M_DMA_FALL = 4'h2;
  localparam logic [MODE_W-1:0] M_DMA_ANY  = 4'h3;
  localparam logic [MODE_W-1:0] M_IRQ_LOW  = 4'h8;
  localparam logic [MODE_W-1:0] M_IRQ_RISE = 4'h9;
  localparam logic [MODE_W-1:0] M_IRQ_FALL = 4'hA;
  localparam logic [MODE_W-1:0] M_IRQ_ANY  = 4'hB;
  localparam logic [MODE_W-1:0] M_IRQ_HIGH = 4'hC;

  // Decoded meaning of one mode code
  typedef struct packed {
    logic to_dma;
    logic to_irq;
    logic on_rise;
    logic on_fall;
    logic on_low;
    logic on_high;
  } evt_sel_t;

endpackage

// File: rtl/pin_evt_decode.sv
module pin_evt_decode
  import pin_evt_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output evt_sel_t          sel
);

  always_comb begin
    sel = '0;
    unique case (mode)
      M_DMA_RISE: begin sel.to_dma = 1'b1; sel.on_rise = 1'b1; end
      M_DMA_FALL: begin sel.to_dma = 1'b1; sel.on_fall = 1'b1; end
      M_DMA_ANY:  begin sel.to_dma = 1'b1; sel.on_rise = 1'b1; sel.on_fall = 1'b1; end
      M_IRQ_LOW:  begin sel.to_irq = 1'b1; sel.on_low  = 1'b1; end
      M_IRQ_RISE: begin sel.to_irq = 1'b1; sel.on_rise = 1'b1; end
      M_IRQ_FALL: begin sel.to_irq = 1'b1; sel.on_fall = 1'b1; end
      M_IRQ_ANY:  begin sel.to_irq = 1'b1; sel.on_rise = 1'b1; sel.on_fall = 1'b1; end
      M_IRQ_HIGH: begin sel.to_irq = 1'b1; sel.on_high = 1'b1; end
      default:    sel = '0;  // off and undefined codes (R1)
    endcase
  end

endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
  import pin_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wd,
  input  logic              sw_clr,
  input  logic              dma_done,
  output logic [MODE_W-1:0] mode_q,
  output logic              flag_q,
  output logic              irq_src,
  output logic              dma_src
);

  logic     prev_q;
  logic     set_evt;
  logic     clr_evt;
  evt_sel_t sel;

  pin_evt_decode u_dec (
    .mode (mode_q),
    .sel  (sel)
  );

  // Edge and level conditions against the previous-cycle level
  assign set_evt = (sel.on_rise &  lvl & ~prev_q)
                 | (sel.on_fall & ~lvl &  prev_q)
                 | (sel.on_low  & ~lvl)
                 | (sel.on_high &  lvl);

  assign clr_evt = sw_clr | (dma_done & sel.to_dma);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      mode_q <= M_OFF;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (mode_we) mode_q <= mode_wd;
      // set dominates clear
      flag_q <= (flag_q & ~clr_evt) | set_evt;
    end
  end

  assign irq_src = flag_q & sel.to_irq;
  assign dma_src = flag_q & sel.to_dma;

endmodule

// File: rtl/pin_evt_regif.sv
module pin_evt_regif
  import pin_evt_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned AW    = 6,
  parameter int unsigned DW    = 32
) (
  input  logic                      reg_wr,
  input  logic [AW-1:0]             reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  input  logic [NPINS*MODE_W-1:0]   mode_vec,
  input  logic [NPINS-1:0]          flag_vec,
  output logic [NPINS-1:0]          mode_we,
  output logic [MODE_W-1:0]         mode_wd,
  output logic [NPINS-1:0]          sw_clr,
  output logic [DW-1:0]             reg_rdata
);

  localparam logic [AW-1:0] STAT_ADDR = AW'(NPINS);

  logic stat_wr;

  assign stat_wr = reg_wr && (reg_addr == STAT_ADDR);
  assign mode_wd = reg_wdata[MODE_W-1:0];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign mode_we[p] = reg_wr && (reg_addr == AW'(p));
    assign sw_clr[p]  = (mode_we[p] && reg_wdata[FLAG_BIT]) || (stat_wr && reg_wdata[p]);
  end

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (reg_addr == AW'(p)) begin
        reg_rdata[MODE_W-1:0] = mode_vec[p*MODE_W +: MODE_W];
        reg_rdata[FLAG_BIT]   = flag_vec[p];
      end
    end
    if (reg_addr == STAT_ADDR) reg_rdata = DW'(flag_vec);
  end

endmodule

// File: rtl/pin_evt_detect.sv
module pin_evt_detect
  import pin_evt_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned AW   = $clog2(NPINS + 1),
  localparam int unsigned DW   = (NPINS > 16) ? NPINS : 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_lvl,
  input  logic [NPINS-1:0] dma_done,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq,
  output logic             dma_req,
  output logic [NPINS-1:0] flags
);

  logic [NPINS*MODE_W-1:0] mode_vec;
  logic [NPINS-1:0]        mode_we;
  logic [MODE_W-1:0]       mode_wd;
  logic [NPINS-1:0]        sw_clr;
  logic [NPINS-1:0]        irq_src;
  logic [NPINS-1:0]        dma_src;

  pin_evt_regif #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regif (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mode_vec  (mode_vec),
    .flag_vec  (flags),
    .mode_we   (mode_we),
    .mode_wd   (mode_wd),
    .sw_clr    (sw_clr),
    .reg_rdata (reg_rdata)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_cell
    pin_evt_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (pin_lvl[p]),
      .mode_we  (mode_we[p]),
      .mode_wd  (mode_wd),
      .sw_clr   (sw_clr[p]),
      .dma_done (dma_done[p]),
      .mode_q   (mode_vec[p*MODE_W +: MODE_W]),
      .flag_q   (flags[p]),
      .irq_src  (irq_src[p]),
      .dma_src  (dma_src[p])
    );
  end

  assign irq     = |irq_src;
  assign dma_req = |dma_src;

endmodule

// File: rtl/pin_evt_checker.sv
module pin_evt_checker
  import pin_evt_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPINS-1:0]        pin_lvl,
  input logic [NPINS-1:0]        dma_done,
  input logic                    reg_wr,
  input logic [NPINS*MODE_W-1:0] mode_vec,
  input logic [NPINS-1:0]        flags,
  input logic                    irq,
  input logic                    dma_req
);

  // R9: a request line needs at least one flag behind it
  a_r9_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flags));
  a_r9_dma_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (|flags));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    logic [MODE_W-1:0] m;
    logic              m_dma;
    assign m     = mode_vec[i*MODE_W +: MODE_W];
    assign m_dma = (m == M_DMA_RISE) || (m == M_DMA_FALL) || (m == M_DMA_ANY);

    // R1: a pin in the off mode never acquires a flag
    a_r1_off_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (m == M_OFF) && !flags[i] |=> !flags[i]);

    // R5: with no write and no completion a flag is sticky
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !reg_wr && !dma_done[i] |=> flags[i]);

    // R4: low-level mode with the pin low always yields a flag
    a_r4_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (m == M_IRQ_LOW) && !pin_lvl[i] |=> flags[i]);

    // R7: completion in DMA mode clears when no new edge arrives
    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && m_dma && dma_done[i] && $stable(pin_lvl[i]) |=> !flags[i]);
  end

endmodule

bind pin_evt_detect pin_evt_checker #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_lvl  (pin_lvl),
  .dma_done (dma_done),
  .reg_wr   (reg_wr),
  .mode_vec (mode_vec),
  .flags    (flags),
  .irq      (irq),
  .dma_req  (dma_req)
);

// File: tb/tb_pin_evt_detect.sv
module tb_pin_evt_detect;

  localparam int unsigned NPINS = 8;
  localparam int unsigned AW    = 4;
  localparam int unsigned DW    = 16;
  localparam logic [AW-1:0] STAT = AW'(NPINS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pin_lvl = '0;
  logic [NPINS-1:0] dma_done = '0;
  logic             reg_wr = 1'b0;
  logic [AW-1:0]    reg_addr = '0;
  logic [DW-1:0]    reg_wdata = '0;
  logic [DW-1:0]    reg_rdata;
  logic             irq;
  logic             dma_req;
  logic [NPINS-1:0] flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pin_evt_detect #(.NPINS(NPINS)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (pin_lvl),
    .dma_done  (dma_done),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .dma_req   (dma_req),
    .flags     (flags)
  );

  // {mode[3:0], level before, level after, exp flag, exp irq, exp dma}
  localparam logic [8:0] VEC [17] = '{
    {4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'h1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'h2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'h2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'h3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'h3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'h9, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'hA, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'hA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'hB, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'h8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'hC, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'hC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'h5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'h8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    reg_addr = a;
    #1;
    check(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state, observed while reset is held
    check("R11 flags in reset", 32'(flags), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 irq after reset", 32'(irq), 32'h0);
    check("R11 dma_req after reset", 32'(dma_req), 32'h0);
    rd_check("R11 pin word after reset", 4'd0, 16'h0000);
    rd_check("R11 status after reset", STAT, 16'h0000);

    // table walk on pin 0
    for (int k = 0; k < 17; k++) begin
      logic [3:0] md;
      string      tag;
      md = VEC[k][8:5];
      if (md inside {4'h1, 4'h2, 4'h3})             tag = "R2";
      else if (md inside {4'h9, 4'hA, 4'hB})        tag = "R3";
      else if (md inside {4'h8, 4'hC})              tag = "R4";
      else                                          tag = "R1";
      wr(4'd0, 16'h0100);
      pin_lvl[0] = VEC[k][4];
      repeat (2) @(negedge clk);
      wr(4'd0, 16'h0100 | 16'(md));
      pin_lvl[0] = VEC[k][3];
      @(negedge clk);
      check($sformatf("%s flag row %0d", tag, k), 32'(flags[0]), 32'(VEC[k][2]));
      check($sformatf("R9 irq row %0d", k),       32'(irq),      32'(VEC[k][1]));
      check($sformatf("R9 dma_req row %0d", k),   32'(dma_req),  32'(VEC[k][0]));
    end
    wr(4'd0, 16'h0100);  // pin 0 back to off, flag cleared

    // R4: held low level sets again despite clear
    pin_lvl[1] = 1'b0;
    wr(4'd1, 16'h0108);
    @(negedge clk);
    check("R4 low level sets flag", 32'(flags[1]), 32'h1);
    wr(4'd1, 16'h0108);
    check("R4 flag re-set while low", 32'(flags[1]), 32'h1);
    pin_lvl[1] = 1'b1;
    @(negedge clk);
    wr(4'd1, 16'h0108);
    check("R4 clear once level gone", 32'(flags[1]), 32'h0);

    // R5 / R10: pin word write-one clear and readback
    pin_lvl[2] = 1'b0;
    wr(4'd2, 16'h0009);
    pin_lvl[2] = 1'b1;
    @(negedge clk);
    check("R12 rising edge sets flag", 32'(flags[2]), 32'h1);
    rd_check("R10 pin word readback", 4'd2, 16'h0109);
    wr(4'd2, 16'h0009);
    check("R5 zero in bit 8 keeps flag", 32'(flags[2]), 32'h1);
    wr(4'd2, 16'h0109);
    check("R5 one in bit 8 clears flag", 32'(flags[2]), 32'h0);
    repeat (2) @(negedge clk);
    check("R12 held level no new edge", 32'(flags[2]), 32'h0);

    // R6: status word partial and full clear
    wr(4'd3, 16'h000B);
    wr(4'd4, 16'h000B);
    pin_lvl[3] = 1'b1;
    pin_lvl[4] = 1'b1;
    #1;
    check("R12 flag not before edge", 32'(flags[3]), 32'h0);
    @(negedge clk);
    rd_check("R6 status readback", STAT, 16'h0018);
    wr(STAT, 16'h0008);
    check("R6 partial status clear", 32'(flags), 32'h10);
    wr(STAT, 16'hFFFF);
    check("R6 full status clear", 32'(flags), 32'h00);

    // R7: DMA completion in DMA and interrupt modes
    wr(4'd5, 16'h0001);
    wr(4'd6, 16'h0009);
    pin_lvl[5] = 1'b1;
    pin_lvl[6] = 1'b1;
    @(negedge clk);
    check("R9 dma_req from DMA pin", 32'(dma_req), 32'h1);
    check("R9 irq from irq pin", 32'(irq), 32'h1);
    dma_done[5] = 1'b1;
    dma_done[6] = 1'b1;
    @(negedge clk);
    dma_done = '0;
    check("R7 done clears DMA flag", 32'(flags[5]), 32'h0);
    check("R7 done ignored in irq mode", 32'(flags[6]), 32'h1);
    check("R7 dma_req dropped", 32'(dma_req), 32'h0);
    wr(STAT, 16'hFFFF);

    // R8: set beats clear in the same cycle
    pin_lvl[7] = 1'b0;
    wr(4'd7, 16'h0009);
    pin_lvl[7] = 1'b1;
    wr(STAT, 16'h0080);
    check("R8 edge beats status clear", 32'(flags[7]), 32'h1);
    pin_lvl[5] = 1'b0;
    @(negedge clk);
    pin_lvl[5] = 1'b1;
    dma_done[5] = 1'b1;
    @(negedge clk);
    dma_done = '0;
    check("R8 edge beats DMA completion", 32'(flags[5]), 32'h1);

    // R10: out-of-range address
    wr(4'd9, 16'hFFFF);
    check("R10 out-of-range write ignored", 32'(flags), 32'hA0);
    rd_check("R10 out-of-range reads zero", 4'd9, 16'h0000);
    rd_check("R10 DMA pin word", 4'd5, 16'h0101);

    done = 1'b1;
    summary();
  end

endmodule